// File: doc/BRIEF.md
# Triggered Waveform Capture Sequencer

This block sequences one-shot waveform captures into a single-port capture buffer. A host raises a start command. A rising edge of that command arms the sequencer. While armed, it waits for a trigger pulse that comes with a valid sample. From that sample on, it writes every valid sample into the buffer at consecutive addresses.

When the highest address has been written, the block stops writing. It then raises a full flag so the host can read the buffer out. The flag stays up until the next start edge, which re-arms the block for a fresh capture starting at address zero, or until a reset.

The sample stream, its valid strobe and the trigger flag come from an upstream stage. That stage has already aligned the trigger with the sample it refers to. The write port (enable, address, data) drives the buffer directly and is combinational from the current state and the inputs.

Top module: `capt_seq`

## Requirements
- R1: While rst_ni is low, and on the first cycle after its release, full_o is 0, wr_en_o is 0 and wr_addr_o is 0; the block is idle.
- R2: The block arms only on a start edge, meaning start_i is 1 in a cycle after being sampled 0. A start_i held high, including one held high through reset release, does not arm it, and while idle nothing is ever written.
- R3: While armed, wr_en_o stays 0 until a cycle with trig_i = 1 and smp_vld_i = 1; in that cycle wr_en_o = 1 and wr_addr_o = 0, with wr_data_o = smp_i.
- R4: During capture, wr_en_o equals smp_vld_i, wr_data_o equals smp_i, and the address rises by one after each write and holds on cycles without a write.
- R5: After the write to address 2^AW-1, full_o is 1 from the next cycle and no further write is made.
- R6: full_o, once set, holds through any trig_i or smp_vld_i activity and while start_i stays at a constant level, until a start edge or a reset.
- R7: A start edge while full clears full_o in the next cycle, returns the address to 0 and re-arms, so the next triggered sample is written at address 0.
- R8: Start edges while armed or capturing are ignored: the address is not reset and the capture continues.
- R9: trig_i during capture has no effect on the address or the write sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command level from the host; its rising edge arms |
| trig_i | input | 1 | Trigger flag aligned with smp_i |
| smp_i | input | DW | Sample data |
| smp_vld_i | input | 1 | Sample valid strobe |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | AW | Buffer write address |
| wr_data_o | output | DW | Buffer write data |
| full_o | output | 1 | Capture complete, buffer ready to read |

## Verification
The bench builds the block with AW = 3 and DW = 8. An eight-entry buffer makes the last-address write, the wrap of the address and the full state reachable within a few dozen cycles. Two complete captures, separated by a re-arm, fit easily in one run. The reduced depth also lets gaps in the valid strobe, stray start edges and triggers inside a capture, and a reset in the middle of a capture with start held high all be placed at known addresses. A behavioural model predicts wr_en_o, wr_addr_o, wr_data_o and full_o every cycle.

// File: rtl/capt_pkg.sv
package capt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FULL  = 2'd3
  } capt_state_e;
endpackage

// File: rtl/capt_edge.sv
module capt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  // reset to 1: a level already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  assert_no_rise_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i && $stable(lvl_i) |=> (lvl_i -> !rise_o));
endmodule

// File: rtl/capt_fsm.sv
module capt_fsm
  import capt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rise_i,
  input  logic        trig_i,
  input  logic        vld_i,
  input  logic        last_i,
  output capt_state_e state_o,
  output logic        wr_en_o,
  output logic        clr_o
);
  capt_state_e state_q, state_d;

  always_comb begin
    wr_en_o = 1'b0;
    unique case (state_q)
      ST_ARMED: wr_en_o = trig_i & vld_i;
      ST_CAPT:  wr_en_o = vld_i;
      default:  wr_en_o = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rise_i) state_d = ST_ARMED;
      ST_ARMED: if (wr_en_o) state_d = last_i ? ST_FULL : ST_CAPT;
      ST_CAPT:  if (wr_en_o && last_i) state_d = ST_FULL;
      ST_FULL:  if (rise_i) state_d = ST_ARMED;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign clr_o   = (state_q == ST_FULL) && rise_i;
  assign state_o = state_q;

  assert_capt_not_rearmed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CAPT |=> (state_q == ST_CAPT || state_q == ST_FULL));

  assert_armed_waits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && !(trig_i && vld_i)) |=> state_q == ST_ARMED);

  assert_idle_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !rise_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/capt_addr.sv
module capt_addr #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] ADDR_MAX = {AW{1'b1}};

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == ADDR_MAX);

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(addr_q));
endmodule

// File: rtl/capt_seq.sv
module capt_seq
  import capt_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          trig_i,
  input  logic [DW-1:0] smp_i,
  input  logic          smp_vld_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          full_o
);
  localparam logic [AW-1:0] ADDR_MAX = {AW{1'b1}};

  logic        start_rise;
  logic        addr_last;
  logic        addr_clr;
  capt_state_e state;

  capt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (start_i),
    .rise_o (start_rise)
  );

  capt_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (start_rise),
    .trig_i  (trig_i),
    .vld_i   (smp_vld_i),
    .last_i  (addr_last),
    .state_o (state),
    .wr_en_o (wr_en_o),
    .clr_o   (addr_clr)
  );

  capt_addr #(.AW(AW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (addr_clr),
    .inc_i  (wr_en_o),
    .addr_o (wr_addr_o),
    .last_o (addr_last)
  );

  assign wr_data_o = smp_i;
  assign full_o    = (state == ST_FULL);

  assert_first_at_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ARMED && wr_en_o) |-> wr_addr_o == '0);

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> wr_addr_o == AW'($past(wr_addr_o) + 1'b1));

  assert_full_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == ADDR_MAX) |=> full_o);

  assert_no_write_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_en_o);

  assert_full_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !start_rise) |=> full_o);

  assert_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && start_rise) |=> (!full_o && wr_addr_o == '0));
endmodule

// File: tb/tb_capt_seq.sv
`timescale 1ns/1ps
module tb_capt_seq;
  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          trig_i = 1'b0;
  logic [DW-1:0] smp_i = '0;
  logic          smp_vld_i = 1'b0;
  logic          wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic          full_o;

  always #2 clk = ~clk;

  capt_seq #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .trig_i(trig_i),
    .smp_i(smp_i), .smp_vld_i(smp_vld_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .full_o(full_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model: 0 idle, 1 armed, 2 capturing, 3 full
  int m_ph = 0;
  int m_addr = 0;
  bit m_prev = 1'b1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit t, input bit v, input int d, input string tag);
    bit e_en;
    bit rise;
    @(negedge clk);
    start_i = s; trig_i = t; smp_vld_i = v; smp_i = DW'(d);
    #1;
    e_en = (m_ph == 1 && t && v) || (m_ph == 2 && v);
    chk(tag, "wr_en", int'(wr_en_o), int'(e_en));
    chk(tag, "wr_addr", int'(wr_addr_o), m_addr);
    chk(tag, "full", int'(full_o), int'(m_ph == 3));
    if (e_en) chk(tag, "wr_data", int'(wr_data_o), d);
    rise = s && !m_prev;
    m_prev = s;
    case (m_ph)
      0: if (rise) m_ph = 1;
      1, 2: if (e_en) begin
        m_ph = (m_addr == DEPTH - 1) ? 3 : 2;
        m_addr = (m_addr + 1) % DEPTH;
      end
      3: if (rise) begin m_ph = 1; m_addr = 0; end
      default: m_ph = 0;
    endcase
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst_ni = 1'b0; start_i = s; trig_i = 1'b0; smp_vld_i = 1'b0;
    m_ph = 0; m_addr = 0; m_prev = 1'b1;
    #1;
    chk("R1", "wr_en in reset", int'(wr_en_o), 0);
    chk("R1", "wr_addr in reset", int'(wr_addr_o), 0);
    chk("R1", "full in reset", int'(full_o), 0);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset(1'b0);
    step(0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R1");
    // idle: trigger and valid ignored
    step(0, 1, 1, 5, "R2");
    step(0, 1, 1, 6, "R2");
    // start edge then held high
    step(1, 0, 0, 0, "R2");
    step(1, 0, 1, 9, "R3");
    step(1, 1, 0, 9, "R3");
    step(1, 0, 1, 9, "R3");
    // trigger with valid sample -> address 0
    step(1, 1, 1, 100, "R3");
    step(1, 0, 1, 101, "R4");
    step(1, 0, 0, 200, "R4");
    step(0, 0, 1, 102, "R4");
    step(1, 0, 1, 103, "R8");
    step(0, 1, 1, 104, "R9");
    step(1, 1, 0, 201, "R9");
    step(1, 0, 1, 105, "R4");
    step(1, 0, 0, 202, "R4");
    step(1, 0, 1, 106, "R4");
    step(1, 0, 1, 107, "R5");
    // full: everything ignored while start level is constant
    step(1, 1, 1, 50, "R5");
    for (int i = 0; i < 4; i++) step(1, i[0], 1, 60 + i, "R6");
    step(0, 1, 1, 70, "R6");
    step(0, 0, 1, 71, "R6");
    // re-arm
    step(1, 0, 1, 72, "R7");
    step(1, 0, 1, 73, "R7");
    step(1, 1, 1, 10, "R7");
    for (int i = 1; i < DEPTH; i++) step(1, 0, 1, 10 + i, "R4");
    step(1, 0, 1, 40, "R5");
    step(0, 0, 0, 0, "R6");
    step(1, 0, 0, 0, "R7");
    step(1, 1, 1, 20, "R7");
    step(1, 0, 1, 21, "R4");
    step(1, 0, 1, 22, "R4");
    // reset mid-capture with start held high
    do_reset(1'b1);
    step(1, 0, 0, 0, "R1");
    step(1, 1, 1, 30, "R2");
    step(1, 1, 1, 31, "R2");
    step(0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");
    step(0, 1, 1, 33, "R3");
    step(0, 0, 1, 34, "R4");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule